// File: doc/BRIEF.md
# Configuration Request Engine

This block lets a host issue single-dword configuration reads and writes towards a PCIe link. Software fills three header registers and a write-data register through a small register port, then sets a start bit in the control register. The engine presents the header and data to a link-side transmit handshake. It then waits for a completion. When the completion arrives it clears the start bit, keeps the 3-bit completion status and stores the returned payload in a read-data register. If no completion arrives within a programmable number of cycles, the engine gives up, clears the start bit and reports a status value reserved for timeouts.

A combinational helper path does the field packing software would otherwise do by hand. From a function, device, bus, register offset, access size and direction it produces the three header dwords and the byte-aligned write data. From the stored read payload it extracts a byte, halfword or dword result. When the last status is nonzero, that result is all ones for the requested width.

Register port map: address 0, 1 and 2 hold header dwords 0, 1 and 2. Address 3 holds write data. Address 4 is control: bit 0 is start/pending and bits 7:5 are status. Address 5 is read data (read-only). Any other address reads as zero.

Top module: `cfg_req_engine`

## Requirements
- R1: After reset every register of the port map reads zero and `tx_valid` is low.
- R2: Header dword 0 from the helper has length 1 in bits 9:0 and type code 4 in bits 28:24. Bits 31:29 hold a format of 2 for a write and 0 for a read. All other bits are zero.
- R3: Header dword 1 from the helper is the byte-enable mask (1, 3 or 0xF for `hlp_size` codes 0, 1 and 2 or 3) shifted left by the low two offset bits.
- R4: Header dword 2 from the helper is laid out as follows: offset bits 11:2 in bits 11:2, function in bits 18:16, device in bits 23:19 and bus in bits 31:24. All other bits are zero.
- R5: `hlp_wdata` is `hlp_wval` shifted left by 8 times the low two offset bits.
- R6: Writing 1 to control bit 0 while it is clear does three things: it sets that bit, it clears the status, and from the next cycle it raises `tx_valid` with the header and write-data registers on the transmit outputs. These outputs hold steady until `tx_ready` is seen.
- R7: A `cpl_valid` pulse while the engine waits for a completion does three things on the following cycle: it clears control bit 0, it places `cpl_status` in control bits 7:5, and it places `cpl_data` in the read-data register.
- R8: If no completion has arrived `TIMEOUT_CYCLES` cycles after the start, control bit 0 clears, the status becomes 7 and `tx_valid` is low.
- R9: While control bit 0 is set, register writes are ignored, including a second start.
- R10: `hlp_rval` is the read-data register shifted right by 8 times the low two offset bits, masked to 8 bits for size code 0, to 16 bits for code 1, and left at 32 bits otherwise.
- R11: When the status is nonzero, `hlp_fail` is high and `hlp_rval` is all ones in the requested width.
- R12: A `cpl_valid` pulse while no completion is awaited leaves the read-data register and status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| tx_valid | output | 1 | Request offered to the link side |
| tx_ready | input | 1 | Link side accepts the request |
| tx_hdr0 | output | 32 | Request header dword 0 |
| tx_hdr1 | output | 32 | Request header dword 1 |
| tx_hdr2 | output | 32 | Request header dword 2 |
| tx_data | output | 32 | Request write payload |
| cpl_valid | input | 1 | Completion present |
| cpl_status | input | 3 | Completion status |
| cpl_data | input | 32 | Completion payload |
| hlp_write | input | 1 | Helper: 1 for a write, 0 for a read |
| hlp_size | input | 2 | Helper: size code 0 byte, 1 halfword, 2/3 dword |
| hlp_offset | input | 12 | Helper: configuration register byte offset |
| hlp_func | input | 3 | Helper: function number |
| hlp_dev | input | 5 | Helper: device number |
| hlp_bus | input | 8 | Helper: bus number |
| hlp_wval | input | 32 | Helper: unaligned write value |
| hlp_hdr0 | output | 32 | Helper: packed header dword 0 |
| hlp_hdr1 | output | 32 | Helper: packed header dword 1 |
| hlp_hdr2 | output | 32 | Helper: packed header dword 2 |
| hlp_wdata | output | 32 | Helper: aligned write data |
| hlp_rval | output | 32 | Helper: extracted read result |
| hlp_fail | output | 1 | Helper: last status was nonzero |

## Verification
On every cycle the assertions check four things. The transmit outputs hold while a request waits for `tx_ready`. A completion is captured with its status and payload on the cycle after it is accepted. Register writes and stray completions leave state untouched. A drop of the pending bit without a completion leaves the timeout status. Other behaviour is only shown by the bench's directed scenarios: the exact field packing for chosen offsets and sizes, the sub-dword extraction, the reset contents and the precise cycle on which the timeout fires.

// File: rtl/cfg_eng_pkg.sv
// Package: shared constants and state type for the configuration request engine.
// Assumes a 32-bit register port and single-dword requests.
package cfg_eng_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2
    } eng_state_t;

    localparam logic [2:0] A_HDR0  = 3'd0;
    localparam logic [2:0] A_HDR1  = 3'd1;
    localparam logic [2:0] A_HDR2  = 3'd2;
    localparam logic [2:0] A_WDAT  = 3'd3;
    localparam logic [2:0] A_CTRL  = 3'd4;
    localparam logic [2:0] A_RDAT  = 3'd5;

    localparam logic [4:0] TYPE_CFG0   = 5'd4;
    localparam logic [2:0] FMT_WRITE   = 3'd2;
    localparam logic [2:0] FMT_READ    = 3'd0;
    localparam logic [9:0] LEN_ONE     = 10'd1;
    localparam logic [2:0] STS_TIMEOUT = 3'b111;
endpackage

// File: rtl/cfg_hdr_pack.sv
// Module: packs header dwords and aligns write data from discrete request fields.
// Assumes size code 0 = byte, 1 = halfword, 2 or 3 = dword; purely combinational.
module cfg_hdr_pack
    import cfg_eng_pkg::*;
(
    input  logic        is_write,
    input  logic [1:0]  size,
    input  logic [11:0] offset,
    input  logic [2:0]  func,
    input  logic [4:0]  dev,
    input  logic [7:0]  bus,
    input  logic [31:0] wval,
    output logic [31:0] hdr0,
    output logic [31:0] hdr1,
    output logic [31:0] hdr2,
    output logic [31:0] wdata_al
);
    logic [31:0] be_base;
    logic [4:0]  bit_shift;

    // Select the unshifted byte-enable mask for the access size.
    always_comb begin
        case (size)
            2'd0:    be_base = 32'h1;
            2'd1:    be_base = 32'h3;
            default: be_base = 32'hF;
        endcase
    end

    assign bit_shift = {offset[1:0], 3'b000};

    // Assemble the three header dwords and the aligned payload.
    always_comb begin
        hdr0     = {(is_write ? FMT_WRITE : FMT_READ), TYPE_CFG0, 14'd0, LEN_ONE};
        hdr1     = be_base << offset[1:0];
        hdr2     = {bus, dev, func, 4'd0, offset[11:2], 2'b00};
        wdata_al = wval << bit_shift;
    end
endmodule

// File: rtl/cfg_rd_extract.sv
// Module: extracts a byte, halfword or dword from the stored read payload.
// Assumes a nonzero status marks the access as failed; then returns all ones.
module cfg_rd_extract (
    input  logic [31:0] rdata,
    input  logic [2:0]  status,
    input  logic [1:0]  size,
    input  logic [11:0] offset,
    output logic [31:0] rval,
    output logic        fail
);
    logic [31:0] shifted;

    assign fail    = (status != 3'd0);
    assign shifted = rdata >> {offset[1:0], 3'b000};

    // Mask the shifted payload to the access width, or force ones on failure.
    always_comb begin
        case (size)
            2'd0:    rval = {24'd0, (fail ? 8'hFF : shifted[7:0])};
            2'd1:    rval = {16'd0, (fail ? 16'hFFFF : shifted[15:0])};
            default: rval = fail ? 32'hFFFF_FFFF : shifted;
        endcase
    end
endmodule

// File: rtl/cfg_req_fsm.sv
// Module: sequences one request through send and completion wait, with a timeout.
// Assumes TIMEOUT_CYCLES >= 2; the counter starts on the start cycle.
module cfg_req_fsm
    import cfg_eng_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tx_ready,
    input  logic cpl_valid,
    output logic send_st,
    output logic wait_st,
    output logic done,
    output logic tmo
);
    localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

    eng_state_t      st_q;
    logic [CW-1:0]   cnt_q;

    assign send_st = (st_q == ST_SEND);
    assign wait_st = (st_q == ST_WAIT);
    assign done    = wait_st && cpl_valid;
    assign tmo     = (st_q != ST_IDLE) && (cnt_q == LAST) && !done;

    // Advance the request state and the elapsed-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (start) st_q <= ST_SEND;
                end
                ST_SEND: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (tmo)           st_q <= ST_IDLE;
                    else if (tx_ready) st_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (done || tmo) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cfg_req_engine.sv
// Module: top of the configuration request engine; holds the register file,
// drives the transmit handshake and captures completions.
// Assumes software only rewrites registers once the pending bit has cleared.
module cfg_req_engine
    import cfg_eng_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 25_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic [31:0] tx_hdr0,
    output logic [31:0] tx_hdr1,
    output logic [31:0] tx_hdr2,
    output logic [31:0] tx_data,
    input  logic        cpl_valid,
    input  logic [2:0]  cpl_status,
    input  logic [31:0] cpl_data,
    input  logic        hlp_write,
    input  logic [1:0]  hlp_size,
    input  logic [11:0] hlp_offset,
    input  logic [2:0]  hlp_func,
    input  logic [4:0]  hlp_dev,
    input  logic [7:0]  hlp_bus,
    input  logic [31:0] hlp_wval,
    output logic [31:0] hlp_hdr0,
    output logic [31:0] hlp_hdr1,
    output logic [31:0] hlp_hdr2,
    output logic [31:0] hlp_wdata,
    output logic [31:0] hlp_rval,
    output logic        hlp_fail
);
    logic [31:0] hdr0_q, hdr1_q, hdr2_q, wdat_q, rdat_q;
    logic        req_q;
    logic [2:0]  sts_q;
    logic        start, send_st, wait_st, cpl_done, tmo;

    assign start = reg_wr && (reg_addr == A_CTRL) && reg_wdata[0] && !req_q;

    cfg_req_fsm #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .tx_ready (tx_ready),
        .cpl_valid(cpl_valid),
        .send_st  (send_st),
        .wait_st  (wait_st),
        .done     (cpl_done),
        .tmo      (tmo)
    );

    // Register file: software writes when idle, engine updates on finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr0_q <= '0;
            hdr1_q <= '0;
            hdr2_q <= '0;
            wdat_q <= '0;
            rdat_q <= '0;
            req_q  <= 1'b0;
            sts_q  <= '0;
        end else begin
            if (reg_wr && !req_q) begin
                case (reg_addr)
                    A_HDR0: hdr0_q <= reg_wdata;
                    A_HDR1: hdr1_q <= reg_wdata;
                    A_HDR2: hdr2_q <= reg_wdata;
                    A_WDAT: wdat_q <= reg_wdata;
                    A_CTRL: if (reg_wdata[0]) begin
                        req_q <= 1'b1;
                        sts_q <= '0;
                    end
                    default: ;
                endcase
            end
            if (cpl_done) begin
                req_q  <= 1'b0;
                sts_q  <= cpl_status;
                rdat_q <= cpl_data;
            end else if (tmo) begin
                req_q <= 1'b0;
                sts_q <= STS_TIMEOUT;
            end
        end
    end

    // Read mux for the register port.
    always_comb begin
        case (reg_addr)
            A_HDR0:  reg_rdata = hdr0_q;
            A_HDR1:  reg_rdata = hdr1_q;
            A_HDR2:  reg_rdata = hdr2_q;
            A_WDAT:  reg_rdata = wdat_q;
            A_CTRL:  reg_rdata = {24'd0, sts_q, 4'd0, req_q};
            A_RDAT:  reg_rdata = rdat_q;
            default: reg_rdata = '0;
        endcase
    end

    assign tx_valid = send_st;
    assign tx_hdr0  = hdr0_q;
    assign tx_hdr1  = hdr1_q;
    assign tx_hdr2  = hdr2_q;
    assign tx_data  = wdat_q;

    cfg_hdr_pack u_pack (
        .is_write(hlp_write),
        .size    (hlp_size),
        .offset  (hlp_offset),
        .func    (hlp_func),
        .dev     (hlp_dev),
        .bus     (hlp_bus),
        .wval    (hlp_wval),
        .hdr0    (hlp_hdr0),
        .hdr1    (hlp_hdr1),
        .hdr2    (hlp_hdr2),
        .wdata_al(hlp_wdata)
    );

    cfg_rd_extract u_extract (
        .rdata (rdat_q),
        .status(sts_q),
        .size  (hlp_size),
        .offset(hlp_offset),
        .rval  (hlp_rval),
        .fail  (hlp_fail)
    );
endmodule

// File: rtl/cfg_req_engine_chk.sv
// Checker: temporal properties of the request engine, bound into the top.
// Assumes the internal names of the top module listed in the bind below.
module cfg_req_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic [31:0] tx_hdr0,
    input logic [31:0] tx_hdr2,
    input logic [31:0] tx_data,
    input logic        cpl_valid,
    input logic [2:0]  cpl_status,
    input logic [31:0] cpl_data,
    input logic [1:0]  hlp_size,
    input logic [31:0] hlp_rval,
    input logic        hlp_fail,
    input logic        req_q,
    input logic [2:0]  sts_q,
    input logic [31:0] rdat_q,
    input logic [31:0] hdr0_q,
    input logic [31:0] wdat_q,
    input logic        wait_st
);
    assert_tx_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> req_q);

    assert_tx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_hdr0) && $stable(tx_hdr2) && $stable(tx_data));

    assert_cpl_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wait_st && cpl_valid |=> !req_q && sts_q == $past(cpl_status) && rdat_q == $past(cpl_data));

    assert_timeout_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_q) && !$past(wait_st && cpl_valid) |-> sts_q == 3'b111);

    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_q && reg_wr |=> $stable(hdr0_q) && $stable(wdat_q));

    assert_fail_ones_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hlp_fail && hlp_size == 2'd0 |-> hlp_rval == 32'h0000_00FF);

    assert_stray_cpl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !wait_st && cpl_valid |=> $stable(rdat_q) && $stable(sts_q));
endmodule

bind cfg_req_engine cfg_req_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_hdr0   (tx_hdr0),
    .tx_hdr2   (tx_hdr2),
    .tx_data   (tx_data),
    .cpl_valid (cpl_valid),
    .cpl_status(cpl_status),
    .cpl_data  (cpl_data),
    .hlp_size  (hlp_size),
    .hlp_rval  (hlp_rval),
    .hlp_fail  (hlp_fail),
    .req_q     (req_q),
    .sts_q     (sts_q),
    .rdat_q    (rdat_q),
    .hdr0_q    (hdr0_q),
    .wdat_q    (wdat_q),
    .wait_st   (wait_st)
);

// File: tb/cfg_req_engine_bench.sv
`timescale 1ns/1ps
// Bench: directed scenarios for the configuration request engine.
module cfg_req_engine_bench;
    localparam int TMO = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [31:0] tx_hdr0, tx_hdr1, tx_hdr2, tx_data;
    logic        cpl_valid = 1'b0;
    logic [2:0]  cpl_status = '0;
    logic [31:0] cpl_data = '0;
    logic        hlp_write = 1'b0;
    logic [1:0]  hlp_size = '0;
    logic [11:0] hlp_offset = '0;
    logic [2:0]  hlp_func = '0;
    logic [4:0]  hlp_dev = '0;
    logic [7:0]  hlp_bus = '0;
    logic [31:0] hlp_wval = '0;
    logic [31:0] hlp_hdr0, hlp_hdr1, hlp_hdr2, hlp_wdata, hlp_rval;
    logic        hlp_fail;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cfg_req_engine #(.TIMEOUT_CYCLES(TMO)) u_cfg_req_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_hdr0(tx_hdr0), .tx_hdr1(tx_hdr1),
        .tx_hdr2(tx_hdr2), .tx_data(tx_data), .cpl_valid(cpl_valid),
        .cpl_status(cpl_status), .cpl_data(cpl_data), .hlp_write(hlp_write),
        .hlp_size(hlp_size), .hlp_offset(hlp_offset), .hlp_func(hlp_func),
        .hlp_dev(hlp_dev), .hlp_bus(hlp_bus), .hlp_wval(hlp_wval),
        .hlp_hdr0(hlp_hdr0), .hlp_hdr1(hlp_hdr1), .hlp_hdr2(hlp_hdr2),
        .hlp_wdata(hlp_wdata), .hlp_rval(hlp_rval), .hlp_fail(hlp_fail)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic pulse_cpl(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        cpl_valid = 1'b1; cpl_status = s; cpl_data = d;
        @(negedge clk);
        cpl_valid = 1'b0;
    endtask

    // R1: every register and tx_valid low after reset.
    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 6; a++) begin
            rd_reg(3'(a), v);
            check("R1 reset register", v, 32'h0);
        end
        check("R1 tx_valid after reset", {31'd0, tx_valid}, 32'h0);
    endtask

    // R2..R5: helper field packing for three access shapes.
    task automatic t_pack();
        hlp_write = 1'b0; hlp_size = 2'd0; hlp_offset = 12'h0A3;
        hlp_func = 3'd5; hlp_dev = 5'h13; hlp_bus = 8'hA5; hlp_wval = 32'h5A;
        #1;
        check("R2 read header0", hlp_hdr0, 32'h0400_0001);
        check("R3 byte enable off3", hlp_hdr1, 32'h8);
        check("R4 header2 fields", hlp_hdr2, 32'hA59D_00A0);
        check("R5 byte data off3", hlp_wdata, 32'h5A00_0000);
        hlp_write = 1'b1; hlp_size = 2'd1; hlp_offset = 12'hFFE;
        hlp_func = 3'd7; hlp_dev = 5'h1F; hlp_bus = 8'hFF; hlp_wval = 32'h1234;
        #1;
        check("R2 write header0", hlp_hdr0, 32'h4400_0001);
        check("R3 halfword enable off2", hlp_hdr1, 32'hC);
        check("R4 header2 all ones", hlp_hdr2, 32'hFFFF_0FFC);
        check("R5 halfword data off2", hlp_wdata, 32'h1234_0000);
        hlp_size = 2'd2; hlp_offset = 12'h010; hlp_wval = 32'hCAFE_F00D;
        #1;
        check("R3 dword enable", hlp_hdr1, 32'hF);
        check("R5 dword data", hlp_wdata, 32'hCAFE_F00D);
    endtask

    // R6, R7, R9: write request with back-pressure, busy writes, good completion.
    task automatic t_write_req();
        logic [31:0] v;
        wr_reg(3'd0, 32'h4400_0001);
        wr_reg(3'd1, 32'h0000_000F);
        wr_reg(3'd2, 32'h0108_0010);
        wr_reg(3'd3, 32'hA5A5_1234);
        tx_ready = 1'b0;
        wr_reg(3'd4, 32'h1);
        rd_reg(3'd4, v);
        check("R6 pending bit set", v, 32'h1);
        for (int i = 0; i < 3; i++) begin
            check("R6 tx_valid held", {31'd0, tx_valid}, 32'h1);
            check("R6 tx header0", tx_hdr0, 32'h4400_0001);
            check("R6 tx data", tx_data, 32'hA5A5_1234);
            @(negedge clk);
        end
        check("R6 tx header2", tx_hdr2, 32'h0108_0010);
        wr_reg(3'd0, 32'hDEAD_0000);
        wr_reg(3'd3, 32'h0);
        rd_reg(3'd0, v);
        check("R9 header0 unchanged while busy", v, 32'h4400_0001);
        rd_reg(3'd3, v);
        check("R9 wdata unchanged while busy", v, 32'hA5A5_1234);
        tx_ready = 1'b1;
        @(negedge clk);
        check("R6 tx_valid drops after ready", {31'd0, tx_valid}, 32'h0);
        wr_reg(3'd4, 32'h1);
        rd_reg(3'd4, v);
        check("R9 restart ignored while waiting", v, 32'h1);
        pulse_cpl(3'd0, 32'h1111_2222);
        rd_reg(3'd4, v);
        check("R7 completion clears pending", v, 32'h0);
        check("R6 no second send", {31'd0, tx_valid}, 32'h0);
    endtask

    // R7, R10: read request returning a payload, then sub-dword extraction.
    task automatic t_read_req();
        logic [31:0] v;
        tx_ready = 1'b1;
        wr_reg(3'd4, 32'h1);
        @(negedge clk);
        pulse_cpl(3'd0, 32'hDEAD_BEEF);
        rd_reg(3'd5, v);
        check("R7 read payload stored", v, 32'hDEAD_BEEF);
        rd_reg(3'd4, v);
        check("R7 status zero", v, 32'h0);
        hlp_size = 2'd0; hlp_offset = 12'h001; #1;
        check("R10 byte at offset1", hlp_rval, 32'h0000_00BE);
        hlp_size = 2'd1; hlp_offset = 12'h002; #1;
        check("R10 halfword at offset2", hlp_rval, 32'h0000_DEAD);
        hlp_size = 2'd2; hlp_offset = 12'h004; #1;
        check("R10 dword", hlp_rval, 32'hDEAD_BEEF);
        check("R11 no fail on status zero", {31'd0, hlp_fail}, 32'h0);
    endtask

    // R7, R11: completion with an error status.
    task automatic t_error_cpl();
        logic [31:0] v;
        wr_reg(3'd4, 32'h1);
        @(negedge clk);
        pulse_cpl(3'd2, 32'h0BAD_0BAD);
        rd_reg(3'd4, v);
        check("R7 status in bits 7:5", v, 32'h40);
        check("R11 fail flag", {31'd0, hlp_fail}, 32'h1);
        hlp_size = 2'd0; #1;
        check("R11 byte all ones", hlp_rval, 32'h0000_00FF);
        hlp_size = 2'd1; #1;
        check("R11 halfword all ones", hlp_rval, 32'h0000_FFFF);
    endtask

    // R8: no completion; pending clears exactly TMO cycles after start.
    task automatic t_timeout();
        logic [31:0] v;
        tx_ready = 1'b1;
        wr_reg(3'd4, 32'h1);
        rd_reg(3'd4, v);
        check("R6 restart clears status", v, 32'h1);
        repeat (TMO - 1) @(negedge clk);
        rd_reg(3'd4, v);
        check("R8 still pending one cycle before limit", v, 32'h1);
        @(negedge clk);
        rd_reg(3'd4, v);
        check("R8 timeout status", v, 32'hE0);
        check("R8 tx_valid low after timeout", {31'd0, tx_valid}, 32'h0);
    endtask

    // R12: completion pulse with nothing outstanding.
    task automatic t_stray();
        logic [31:0] v;
        pulse_cpl(3'd1, 32'h7777_7777);
        rd_reg(3'd5, v);
        check("R12 read data unchanged", v, 32'h0BAD_0BAD);
        rd_reg(3'd4, v);
        check("R12 status unchanged", v, 32'hE0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pack();
        t_write_req();
        t_read_req();
        t_error_cpl();
        t_timeout();
        t_stray();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule